// File: doc/BRIEF.md
# Glitch-Free Processor Clock Source Selector

This block picks one of several free-running clocks to drive a processor clock, and the processor can change the choice while it runs. The processor writes a source number to the block's port. The write strobe is active low and sits low while the bus phase-2 signal is high. The falling edge of the clock currently in use that ends the write cycle stops the processor clock, which then stays low. When the strobe goes high again, the new source number is captured and routes the matching input through the source multiplexer.

The processor clock then stays low while a logic one walks through two enable stages. Both stages are clocked on the falling edge of the newly chosen source. When the second stage goes high, the output follows the new source again. The enable changes only while the multiplexed clock is low, so every pulse that reaches the processor has a full half-period. An asynchronous reset clears both enable stages and loads a boot-up source number, so the processor starts on a known clock.

Top module: `clk_source_select`

## Requirements
- R1: While `rst_n` is low, `cpu_clk` is low, and the select register holds `BOOT_SEL` (default 0).
- R2: A falling edge of the selected clock that arrives while `wr_n` is low clears both enable stages. `cpu_clk` then makes no rising edge while `wr_n` stays low.
- R3: The select register loads `din` on the rising edge of `wr_n`. A value k routes `clk_src[k]` to `cpu_clk`, so once enabled, `cpu_clk` falls one half-period of `clk_src[k]` after it rises.
- R4: After the strobe is released, the first falling edge of the new source sets stage one and the next falling edge sets stage two. Stage two therefore goes high more than one and at most two full periods of the new clock after the release.
- R5: After a write, the first rising edge of `cpu_clk` is the first rising edge of the new source that follows the second falling edge of that source after `wr_n` rises.
- R6: Every high pulse on `cpu_clk` lasts exactly one half-period of one of the input clocks. No low interval is shorter than the shortest input half-period.
- R7: After `rst_n` is released, the first rising edge of `cpu_clk` follows the rule of R5 applied to the `BOOT_SEL` source, counted from the release.
- R8: A write of the value already selected still produces the full low-hold interval of R5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_src | input | 2**SEL_W | Free-running source clocks; bit k is source k |
| wr_n | input | 1 | Active-low write strobe for the select port |
| din | input | SEL_W | Source number written by the processor |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_clk | output | 1 | Gated processor clock |

## Verification
A small configuration with four sources is used. Their half-periods are 5, 7, 11 and 17 ns, pairwise coprime, so no two sources keep a fixed phase relation. Every ordered pair of old and new source is written, including each source onto itself. For each switch, the exact time of the first output rise is compared with the time computed from the new source's edge grid. This separates a correct two-stage wait from one or three stages, from syncing on the old clock, and from skipping the hold when the value does not change (R8). The width of the first pulse after each switch identifies which source was selected. A monitor of pulse widths over the whole run catches any runt. A reset in the middle of the run, with a non-boot source selected, checks the return to the boot source.

// File: rtl/clksel_pkg.sv
`timescale 1ns/100ps
package clksel_pkg;

  // Number of clock sources addressed by a select field of the given width.
  function automatic int unsigned src_count(input int unsigned sel_w);
    return 32'd1 << sel_w;
  endfunction

  // Number of falling edges of the new source needed before the gate opens.
  localparam int unsigned SYNC_STAGES = 2;

endpackage

// File: rtl/clksel_reg.sv
`timescale 1ns/100ps
module clksel_reg #(
  parameter int unsigned SEL_W    = 2,
  parameter int unsigned BOOT_SEL = 0
) (
  input  logic             wr_n,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] din,
  output logic [SEL_W-1:0] sel_q
);

  localparam logic [SEL_W-1:0] BootVal = SEL_W'(BOOT_SEL);

  // The strobe rises at the end of the write, so the data is captured on that edge.
  always_ff @(posedge wr_n or negedge rst_n) begin
    if (!rst_n) sel_q <= BootVal;
    else        sel_q <= din;
  end

endmodule

// File: rtl/clksel_mux.sv
`timescale 1ns/100ps
module clksel_mux #(
  parameter int unsigned SEL_W = 2
) (
  input  logic [clksel_pkg::src_count(SEL_W)-1:0] clk_src,
  input  logic [SEL_W-1:0]                        sel,
  output logic                                    mux_clk
);

  localparam int unsigned NSrc = clksel_pkg::src_count(SEL_W);

  logic [NSrc-1:0] term;

  // An AND-OR tree: only the decoded source can drive the output.
  for (genvar g = 0; g < NSrc; g++) begin : g_term
    assign term[g] = clk_src[g] & (sel == SEL_W'(g));
  end

  assign mux_clk = |term;

endmodule

// File: rtl/clksel_sync.sv
`timescale 1ns/100ps
module clksel_sync (
  input  logic mux_clk,
  input  logic rst_n,
  input  logic wr_n,
  output logic en_q
);

  logic stage1_q;

  // Both stages use the falling edge, so the enable moves only while the clock is low.
  always_ff @(negedge mux_clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      en_q     <= 1'b0;
    end else if (!wr_n) begin
      stage1_q <= 1'b0;
      en_q     <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      en_q     <= stage1_q;
    end
  end

  AST_WRITE_CLEARS_STAGES: assert property (@(negedge mux_clk) disable iff (!rst_n)
    !wr_n |=> (!stage1_q && !en_q)); // R2

  AST_SECOND_FOLLOWS_FIRST: assert property (@(negedge mux_clk) disable iff (!rst_n)
    $rose(en_q) |-> $past(stage1_q)); // R4

endmodule

// File: rtl/clk_source_select.sv
`timescale 1ns/100ps
module clk_source_select #(
  parameter int unsigned SEL_W    = 2,
  parameter int unsigned BOOT_SEL = 0
) (
  input  logic [clksel_pkg::src_count(SEL_W)-1:0] clk_src,
  input  logic                                    wr_n,
  input  logic [SEL_W-1:0]                        din,
  input  logic                                    rst_n,
  output logic                                    cpu_clk
);

  logic [SEL_W-1:0] sel_q;
  logic             mux_clk;
  logic             gate_en;

  clksel_reg #(.SEL_W(SEL_W), .BOOT_SEL(BOOT_SEL)) u_reg (
    .wr_n (wr_n),
    .rst_n(rst_n),
    .din  (din),
    .sel_q(sel_q)
  );

  clksel_mux #(.SEL_W(SEL_W)) u_mux (
    .clk_src(clk_src),
    .sel    (sel_q),
    .mux_clk(mux_clk)
  );

  clksel_sync u_sync (
    .mux_clk(mux_clk),
    .rst_n  (rst_n),
    .wr_n   (wr_n),
    .en_q   (gate_en)
  );

  assign cpu_clk = mux_clk & gate_en;

  AST_NO_RISE_DURING_WRITE: assert property (@(posedge cpu_clk) disable iff (!rst_n)
    wr_n); // R2

  AST_SEL_STABLE_WITHOUT_WRITE: assert property (@(negedge mux_clk) disable iff (!rst_n)
    (wr_n && $past(wr_n)) |-> $stable(sel_q)); // R3

endmodule

// File: tb/clk_source_select_bench.sv
`timescale 1ns/100ps
module clk_source_select_bench;

  localparam int SEL_W = 2;

  logic       c0, c1, c2, c3;
  logic [3:0] clk_src;
  logic       wr_n;
  logic [1:0] din;
  logic       rst_n;
  logic       cpu_clk;

  int  n_cmp = 0;
  int  n_bad = 0;
  int  rise_cnt = 0;
  real last_rise = -1.0;
  real last_fall = -1.0;
  int  cur = 0;

  function automatic real half(input int i);
    case (i)
      0: return 5.0;
      1: return 7.0;
      2: return 11.0;
      default: return 17.0;
    endcase
  endfunction

  // Source i starts low at time 0 and falls at every multiple of its period.
  function automatic real nxt_fall(input int i, input real t);
    real p;
    p = 2.0 * half(i);
    return ($floor(t / p) + 1.0) * p;
  endfunction

  // Rising edges lie at odd multiples of the half-period.
  function automatic real nxt_rise(input int i, input real t);
    real h, r;
    h = half(i);
    r = $floor((t + h) / (2.0 * h)) * 2.0 * h + h;
    if (r <= t) r = r + 2.0 * h;
    return r;
  endfunction

  function automatic bit near(input real a, input real b);
    return (a - b < 0.05) && (b - a < 0.05);
  endfunction

  task automatic chk(input bit ok, input string req, input real act, input real exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s at %0t: actual %0.1f expected %0.1f", req, $realtime, act, exp);
    end
  endtask

  clk_source_select #(.SEL_W(SEL_W), .BOOT_SEL(0)) u_clk_source_select (
    .clk_src(clk_src),
    .wr_n   (wr_n),
    .din    (din),
    .rst_n  (rst_n),
    .cpu_clk(cpu_clk)
  );

  assign clk_src = {c3, c2, c1, c0};

  initial begin c0 = 1'b0; forever #5.0  c0 = ~c0; end // 100 MHz
  initial begin c1 = 1'b0; forever #7.0  c1 = ~c1; end
  initial begin c2 = 1'b0; forever #11.0 c2 = ~c2; end
  initial begin c3 = 1'b0; forever #17.0 c3 = ~c3; end

  // Pulse-width monitor: R6
  always @(posedge cpu_clk) begin
    if (last_fall >= 0.0)
      chk(($realtime - last_fall) > 4.95, "R6 low time", $realtime - last_fall, 5.0);
    rise_cnt++;
    last_rise = $realtime;
  end

  always @(negedge cpu_clk) begin
    if (last_rise >= 0.0 && rst_n) begin
      real w;
      w = $realtime - last_rise;
      chk(near(w, 5.0) || near(w, 7.0) || near(w, 11.0) || near(w, 17.0),
          "R6 high time", w, half(cur));
    end
    last_fall = $realtime;
  end

  task automatic wait_until(input real t);
    #(t - $realtime);
  endtask

  task automatic do_write(input int nv);
    real t, tr, te;
    int  base;
    t = nxt_rise(cur, $realtime);
    wait_until(t + 0.3);
    din  = nv[1:0];
    wr_n = 1'b0;
    base = rise_cnt;
    t = nxt_fall(cur, $realtime);
    wait_until(t + 0.3);
    chk(cpu_clk == 1'b0, "R2 low after clearing edge", real'(cpu_clk), 0.0);
    wr_n = 1'b1;
    tr = $realtime;
    chk(rise_cnt == base, "R2 no rise during strobe", real'(rise_cnt - base), 0.0);
    te = nxt_rise(nv, nxt_fall(nv, nxt_fall(nv, tr)));
    wait_until(te + 0.2);
    chk(rise_cnt == base + 1 && near(last_rise, te),
        (nv == cur) ? "R8 hold on same value" : "R5 first rise after switch", last_rise, te);
    chk((last_rise - half(nv) - tr) > 2.0 * half(nv) &&
        (last_rise - half(nv) - tr) <= 4.0 * half(nv) + 0.05,
        "R4 second stage window", last_rise - half(nv) - tr, 3.0 * half(nv));
    wait_until(te + half(nv) + 0.2);
    chk(near(last_fall, te + half(nv)), "R3 pulse of selected source",
        last_fall - te, half(nv));
    cur = nv;
  endtask

  initial begin
    #200000;
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    real t, te;
    int  base;
    rst_n = 1'b0;
    wr_n  = 1'b1;
    din   = 2'd0;
    #2.0;
    chk(cpu_clk == 1'b0, "R1 output low in reset", real'(cpu_clk), 0.0);
    wait_until(20.3);
    rst_n = 1'b1;
    te = nxt_rise(0, nxt_fall(0, nxt_fall(0, 20.3)));
    wait_until(te + 0.2);
    chk(rise_cnt == 1 && near(last_rise, te), "R7 boot start", last_rise, te);

    // Every ordered pair of sources, including each onto itself.
    for (int a = 0; a < 4; a++) begin
      for (int b = 0; b < 4; b++) begin
        do_write(a);
        do_write(b);
      end
    end

    // Reset in the middle of the run, with a non-boot source selected.
    t = nxt_fall(cur, $realtime);
    wait_until(t + 0.3);
    rst_n = 1'b0;
    cur = 0;
    #1.0;
    chk(cpu_clk == 1'b0, "R1 output low in mid-run reset", real'(cpu_clk), 0.0);
    base = rise_cnt;
    #40.0;
    chk(rise_cnt == base, "R1 no pulses in reset", real'(rise_cnt - base), 0.0);
    rst_n = 1'b1;
    te = nxt_rise(0, nxt_fall(0, nxt_fall(0, $realtime)));
    wait_until(te + 0.2);
    chk(rise_cnt == base + 1 && near(last_rise, te), "R7 restart on boot source", last_rise, te);
    wait_until(te + 5.2);
    chk(near(last_fall, te + 5.0), "R1 boot source selected", last_fall - te, 5.0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule